// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the word address for a synchronous burst memory. A start address is captured from the external address bus when either of two address strobes is sampled on a rising clock edge while the chip is selected. After that, each clock edge on which the advance input is high steps the low burst bits to the next position in the burst. The upper address bits stay at the captured value for the whole burst.

A mode input picks the burst ordering. In linear order the low bits count up from the start value and wrap within the burst. In interleaved order the low bits are the start value XORed with the beat count. A valid output shows whether a selected burst is in progress.

The chip is selected only when all three select inputs are active. One select is active-low and two are active-high. The strobe driven by a processor is ignored while the chip is not selected. The strobe driven by a cache controller deselects the block in that case.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first falling edge after it, addr_valid is 0 and addr_out is 0.
- R2: The chip is selected when sel_a and sel_b are 1 and sel_n is 0. A rising edge that samples stb_proc or stb_ctrl high while the chip is selected loads addr_in. Afterwards addr_out equals addr_in and addr_valid is 1. A load overrides advance.
- R3: With order_il at 0, beat k of a burst (k = number of accepted advances since the load) shows low bits equal to (start + k) mod 4.
- R4: With order_il at 1, beat k shows low bits equal to start XOR (k mod 4).
- R5: The address bits above the two burst bits never change except on a load.
- R6: After four advances the low bits return to the start value, with no carry into the upper bits.
- R7: With no strobe and advance low, addr_out and addr_valid hold.
- R8: stb_proc sampled while the chip is not selected, with stb_ctrl low, has no effect. An advance on the same edge is still accepted.
- R9: stb_ctrl sampled while the chip is not selected drops addr_valid to 0 and leaves addr_out unchanged.
- R10: advance has no effect while addr_valid is 0.
- R11: order_il acts on addr_out in the same cycle it changes, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External start address |
| stb_proc | input | 1 | Processor-side address strobe, active high |
| stb_ctrl | input | 1 | Controller-side address strobe, active high |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| advance | input | 1 | Step the burst by one beat |
| order_il | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_out | output | ADDR_W | Current word address |
| addr_valid | output | 1 | A selected burst is in progress |

## Verification
Loads, steps, holds and deselects all show on the outputs one rising edge after the inputs that cause them. A change on order_il shows up on addr_out with no clock edge at all. The bench changes inputs just after a falling edge. It updates its behavioural model as of the next rising edge and compares at the falling edge that follows, so every comparison sees exactly one register stage. The mode is changed mid-burst, so any clocked use of the mode input would show up one cycle late.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

   typedef enum logic [1:0] {
      CMD_HOLD = 2'd0,
      CMD_LOAD = 2'd1,
      CMD_STEP = 2'd2,
      CMD_DROP = 2'd3
   } burst_cmd_e;

endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
   import burst_addr_pkg::*;
(
   input  logic       stb_proc,
   input  logic       stb_ctrl,
   input  logic       chip_on,
   input  logic       advance,
   input  logic       valid_q,
   output burst_cmd_e cmd
);

   always_comb begin
      if ((stb_proc || stb_ctrl) && chip_on) begin
         cmd = CMD_LOAD;
      end else if (stb_ctrl) begin
         cmd = CMD_DROP;
      end else if (advance && valid_q) begin
         cmd = CMD_STEP;
      end else begin
         cmd = CMD_HOLD;
      end
   end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_addr_pkg::*;
#(
   parameter int BURST_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  burst_cmd_e         cmd,
   input  logic [BURST_W-1:0] seed,
   input  logic               order_il,
   output logic [BURST_W-1:0] low_out
);

   logic [BURST_W-1:0] start_q;
   logic [BURST_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         cnt_q   <= '0;
      end else begin
         case (cmd)
            CMD_LOAD: begin
               start_q <= seed;
               cnt_q   <= '0;
            end
            CMD_STEP: cnt_q <= cnt_q + 1'b1;
            default:  ;
         endcase
      end
   end

   generate
      if (BURST_W == 1) begin : g_single
         // With a single burst bit, both orders give the same sequence.
         logic unused_mode;
         assign unused_mode = order_il;
         assign low_out     = start_q ^ cnt_q;
      end else begin : g_multi
         logic [BURST_W-1:0] lin_low;
         logic [BURST_W-1:0] il_low;
         assign lin_low = start_q + cnt_q;
         assign il_low  = start_q ^ cnt_q;
         assign low_out = order_il ? il_low : lin_low;
      end
   endgenerate

   AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_LOAD |=> (cnt_q == '0) && (start_q == $past(seed)));  // R2
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_HOLD || cmd == CMD_DROP) |=> $stable(cnt_q) && $stable(start_q));  // R7
   AST_WRAP_START: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_STEP && cnt_q == {BURST_W{1'b1}}) |=> cnt_q == '0);  // R6

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int ADDR_W  = 17,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              stb_proc,
   input  logic              stb_ctrl,
   input  logic              sel_a,
   input  logic              sel_b,
   input  logic              sel_n,
   input  logic              advance,
   input  logic              order_il,
   output logic [ADDR_W-1:0] addr_out,
   output logic              addr_valid
);

   localparam int UP_W = ADDR_W - BURST_W;

   initial begin
      assert (BURST_W >= 1 && BURST_W < ADDR_W)
         else $error("burst_addr_gen: BURST_W must be at least 1 and below ADDR_W");
   end

   logic               chip_on;
   burst_cmd_e         cmd;
   logic [UP_W-1:0]    upper_q;
   logic               valid_q;
   logic [BURST_W-1:0] low_w;

   assign chip_on = sel_a && sel_b && !sel_n;

   burst_cmd_dec u_dec (
      .stb_proc (stb_proc),
      .stb_ctrl (stb_ctrl),
      .chip_on  (chip_on),
      .advance  (advance),
      .valid_q  (valid_q),
      .cmd      (cmd)
   );

   burst_seq #(.BURST_W(BURST_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .seed     (addr_in[BURST_W-1:0]),
      .order_il (order_il),
      .low_out  (low_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upper_q <= '0;
         valid_q <= 1'b0;
      end else begin
         case (cmd)
            CMD_LOAD: begin
               upper_q <= addr_in[ADDR_W-1:BURST_W];
               valid_q <= 1'b1;
            end
            CMD_DROP: valid_q <= 1'b0;
            default:  ;
         endcase
      end
   end

   assign addr_out   = {upper_q, low_w};
   assign addr_valid = valid_q;

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ((stb_proc || stb_ctrl) && chip_on) |=> addr_valid
         && (addr_out[ADDR_W-1:BURST_W] == $past(addr_in[ADDR_W-1:BURST_W])));  // R2
   AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !((stb_proc || stb_ctrl) && chip_on) |=> $stable(addr_out[ADDR_W-1:BURST_W]));  // R5
   AST_PROC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_proc && !stb_ctrl && !chip_on && !advance) |=> $stable(addr_valid));  // R8
   AST_CTRL_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_ctrl && !chip_on) |=> !addr_valid);  // R9
   AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_valid && !((stb_proc || stb_ctrl) && chip_on)) |=> !addr_valid);  // R10

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

   localparam int AW = 17;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr_in;
   logic          stb_proc;
   logic          stb_ctrl;
   logic          sel_a;
   logic          sel_b;
   logic          sel_n;
   logic          advance;
   logic          order_il;
   logic [AW-1:0] addr_out;
   logic          addr_valid;

   int vectors = 0;
   int errors  = 0;

   // Behavioural model state
   int m_valid = 0;
   int m_upper = 0;
   int m_start = 0;
   int m_beats = 0;

   always #10 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BURST_W(BW)) u_burst_addr_gen (
      .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
      .stb_proc(stb_proc), .stb_ctrl(stb_ctrl),
      .sel_a(sel_a), .sel_b(sel_b), .sel_n(sel_n),
      .advance(advance), .order_il(order_il),
      .addr_out(addr_out), .addr_valid(addr_valid)
   );

   function automatic int exp_addr();
      int lo;
      if (order_il) lo = m_start ^ (m_beats % 4);
      else          lo = (m_start + m_beats) % 4;
      return (m_upper * 4) + lo;
   endfunction

   task automatic compare(input string tag);
      int ea;
      ea = exp_addr();
      vectors++;
      if (addr_out !== ea[AW-1:0] || addr_valid !== (m_valid != 0)) begin
         errors++;
         $display("FAIL %s: addr=%h valid=%0b expected addr=%h valid=%0d",
                  tag, addr_out, addr_valid, ea[AW-1:0], m_valid);
      end
   endtask

   // Drive inputs after a falling edge, step the model as of the next rising edge,
   // then compare at the following falling edge.
   task automatic cyc(input bit sp, input bit sc, input bit on, input bit adv,
                      input bit md, input int a, input string tag);
      bit sel;
      stb_proc = sp; stb_ctrl = sc; advance = adv; order_il = md;
      addr_in  = a[AW-1:0];
      if (on) begin sel_a = 1; sel_b = 1; sel_n = 0; end
      else    begin sel_a = 1; sel_b = 0; sel_n = 0; end
      sel = on;
      if ((sp || sc) && sel) begin
         m_valid = 1; m_upper = (a >> BW) & ((1 << (AW - BW)) - 1);
         m_start = a & 3; m_beats = 0;
      end else if (sc) begin
         m_valid = 0;
      end else if (adv && m_valid != 0) begin
         m_beats = (m_beats + 1) % 4;
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      rst_n = 0; addr_in = '0; stb_proc = 0; stb_ctrl = 0;
      sel_a = 0; sel_b = 0; sel_n = 1; advance = 0; order_il = 0;
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1;
      @(negedge clk);
      compare("R1 after reset");

      cyc(0, 0, 1, 1, 0, 0, "R10 advance idle");
      // Linear burst from low bits 2
      cyc(1, 0, 1, 0, 0, 'h1_2346, "R2 proc load");
      for (int k = 0; k < 4; k++) cyc(0, 0, 1, 1, 0, 'h0_FFFF, "R3 R5 R6 linear step");
      cyc(0, 0, 1, 0, 0, 'h0_0001, "R7 hold");
      cyc(0, 0, 0, 0, 0, 'h0_0003, "R7 hold deselected pins");
      // Interleaved burst from low bits 3 via controller strobe
      cyc(0, 1, 1, 1, 1, 'h0_ABC7, "R2 ctrl load beats advance");
      for (int k = 0; k < 5; k++) cyc(0, 0, 1, 1, 1, 'h1_0000, "R4 R6 interleaved step");
      // Mode flips mid burst, combinational effect
      order_il = 0; #1; compare("R11 mode to linear");
      order_il = 1; #1; compare("R11 mode to interleaved");
      // Processor strobe while deselected
      cyc(1, 0, 0, 0, 1, 'h1_5550, "R8 proc ignored");
      cyc(1, 0, 0, 1, 1, 'h1_5550, "R8 proc ignored advance kept");
      // Controller strobe while deselected
      cyc(0, 1, 0, 0, 0, 'h0_1111, "R9 ctrl deselect");
      cyc(0, 0, 1, 1, 0, 'h0_2222, "R10 no step after deselect");
      // All starting offsets in both orders
      for (int s = 0; s < 4; s++) begin
         for (int md = 0; md < 2; md++) begin
            cyc(1, 0, 1, 0, md[0], 'h1_FFFC + s, "R2 reload");
            for (int k = 0; k < 4; k++) cyc(0, 0, 1, 1, md[0], 0, md ? "R4 sweep" : "R3 sweep");
            cyc(0, 0, 1, 0, md[0], 0, "R6 wrapped to start");
         end
      end
      // Load overrides advance, then reset clears
      cyc(0, 1, 1, 1, 0, 'h0_3005, "R2 load over advance");
      rst_n = 0; m_valid = 0; m_upper = 0; m_start = 0; m_beats = 0;
      @(negedge clk);
      compare("R1 reset mid burst");
      rst_n = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule